// File: doc/BRIEF.md
# Receive DMA Engine with Buffered-Byte Drain

This block sits on the receive side of a byte-oriented serial port. Incoming bytes arrive on a valid/ready stream. When no transfer is outstanding, they are stored in an internal FIFO. Software arms a transfer by writing a byte length. The engine first moves whatever the FIFO already holds, oldest first, into memory through a byte-wide write port that uses a ready handshake. It only keeps the shortfall outstanding. That remainder is then filled by steering newly arriving bytes straight to memory, so they never enter the FIFO.

Software loads the destination pointer with a separate write. Each byte written to memory advances the pointer by one. The pointer and the outstanding length are both visible as outputs. The engine also publishes how many bytes it can take right now. This is the outstanding length while a transfer is pending, and the free FIFO space otherwise. While the FIFO contents are being moved, the engine reports itself busy and refuses new serial bytes, so ordering is preserved.

Top module: `rxdma_engine`

## Requirements
- R1: After reset, dmaAddr is 0, dmaRemain is 0, fifoCount is 0, busy is 0 and memValid is 0.
- R2: A length write of L accepted with C bytes buffered moves min(C, L) bytes out of the FIFO and leaves dmaRemain = L - C when C < L, otherwise 0.
- R3: Every accepted memory write (memValid and memReady both high) carries memAddr equal to the current dmaAddr, and dmaAddr then rises by one. Bytes moved out of the FIFO leave in arrival order.
- R4: While dmaRemain is nonzero and the engine is not busy, an arriving byte is presented on memValid/memData, rxReady follows memReady, each accepted byte decrements dmaRemain, and fifoCount does not grow.
- R5: While dmaRemain is 0 and the engine is not busy, each accepted byte is pushed into the FIFO, and rxReady is low when fifoCount equals DEPTH.
- R6: A pointer write loads dmaAddr, clears dmaRemain, ends any drain in progress, and takes precedence over a length write in the same cycle.
- R7: rxCapacity equals dmaRemain when that is nonzero, otherwise DEPTH - fifoCount.
- R8: dmaAddr and dmaRemain always show the advanced pointer and the outstanding length.
- R9: busy is high from the cycle after a length write that finds both L and C nonzero until the last drained byte is accepted. rxReady is low while busy and in any cycle with a length write.
- R10: A length write while busy has no effect on dmaRemain, the drain length or the pointer.
- R11: While busy and memReady is low, memValid stays high with memAddr and memData held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Incoming serial byte valid |
| rxData | input | DW | Incoming serial byte |
| rxReady | output | 1 | Engine accepts the incoming byte |
| rxCapacity | output | CW | Bytes the engine can take now |
| addrWrEn | input | 1 | Pointer register write strobe |
| addrWrData | input | AW | New destination pointer |
| cntWrEn | input | 1 | Length register write strobe, starts a transfer |
| cntWrData | input | CW | Requested transfer length in bytes |
| dmaAddr | output | AW | Current destination pointer |
| dmaRemain | output | CW | Outstanding bytes to be taken from the line |
| fifoCount | output | $clog2(DEPTH+1) | FIFO occupancy |
| busy | output | 1 | FIFO drain in progress |
| memValid | output | 1 | Memory byte write request |
| memAddr | output | AW | Memory write address |
| memData | output | DW | Memory write byte |
| memReady | input | 1 | Memory accepts the write |

## Verification
The hardest situations to reach are a length write or a pointer write that lands while a drain is stalled by memory backpressure. A length write that finds the FIFO exactly full is also hard to reach. The stimulus gets there with directed phases. Memory readiness is held at a low rate while bytes stream in until the FIFO fills. Length and pointer writes are then forced in the middle of the resulting slow drain. A long random phase follows, with varying traffic and readiness rates and sparse register writes, to cover overlapping direct transfers and re-armed lengths.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic {ST_IDLE, ST_DRAIN} dmaState_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic advance;
    logic loadPtr;
    logic loadCount;
    logic decRemain;
    logic decDrain;
    logic abort;
  } dmaCtl_t;
endpackage

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxValid,
  input  logic    cntWrEn,
  input  logic    addrWrEn,
  input  logic    memReady,
  input  logic    remainZero,
  input  logic    fifoFull,
  input  logic    drainLast,
  input  logic    drainNeeded,
  output dmaCtl_t ctl,
  output logic    busy,
  output logic    rxReady,
  output logic    memValid,
  output logic    drainSel
);
  dmaState_t state, stateNext;
  logic beat;
  logic directOk;

  always_comb begin
    busy     = (state == ST_DRAIN);
    drainSel = busy;
    directOk = !busy && !remainZero && !cntWrEn;
    memValid = busy || (directOk && rxValid);
    rxReady  = !busy && !cntWrEn && (remainZero ? !fifoFull : memReady);
    beat     = memValid && memReady;

    ctl           = '0;
    ctl.pop       = busy && beat;
    ctl.decDrain  = busy && beat;
    ctl.decRemain = !busy && beat;
    ctl.advance   = beat;
    ctl.push      = rxValid && rxReady && remainZero;
    ctl.loadPtr   = addrWrEn;
    ctl.abort     = addrWrEn;
    ctl.loadCount = cntWrEn && !busy && !addrWrEn;
  end

  always_comb begin
    stateNext = state;
    if (addrWrEn)
      stateNext = ST_IDLE;
    else if (busy && beat && drainLast)
      stateNext = ST_IDLE;
    else if (ctl.loadCount && drainNeeded)
      stateNext = ST_DRAIN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/rxdma_dpath.sv
module rxdma_dpath
  import rxdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rstN,
  input  dmaCtl_t       ctl,
  input  logic          drainSel,
  input  logic [DW-1:0] rxData,
  input  logic [AW-1:0] addrIn,
  input  logic [CW-1:0] lenIn,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] remain,
  output logic [NW-1:0] count,
  output logic [CW-1:0] capacity,
  output logic [DW-1:0] memData,
  output logic          remainZero,
  output logic          fifoFull,
  output logic          drainLast,
  output logic          drainNeeded
);
  logic [DW-1:0] store [DEPTH];
  logic [IW-1:0] rdIdx, wrIdx;
  logic [NW-1:0] drainLeft;
  logic [CW-1:0] occWide;

  function automatic logic [IW-1:0] wrapInc(input logic [IW-1:0] v);
    return (v == IW'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    occWide     = CW'(count);
    remainZero  = (remain == '0);
    fifoFull    = (count == NW'(DEPTH));
    drainLast   = (drainLeft == NW'(1));
    drainNeeded = (count != '0) && (lenIn != '0);
    capacity    = remainZero ? (CW'(DEPTH) - occWide) : remain;
    memData     = drainSel ? store[rdIdx] : rxData;
  end

  always_ff @(posedge clk) begin
    if (ctl.push) store[wrIdx] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx <= '0;
      wrIdx <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrIdx <= wrapInc(wrIdx);
      if (ctl.pop)  rdIdx <= wrapInc(rdIdx);
      count <= count + NW'(ctl.push) - NW'(ctl.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      remain    <= '0;
      drainLeft <= '0;
    end else begin
      if (ctl.loadPtr)      ptr <= addrIn;
      else if (ctl.advance) ptr <= ptr + 1'b1;

      if (ctl.abort) begin
        remain    <= '0;
        drainLeft <= '0;
      end else if (ctl.loadCount) begin
        if (occWide < lenIn) begin
          drainLeft <= count;
          remain    <= lenIn - occWide;
        end else begin
          drainLeft <= NW'(lenIn);
          remain    <= '0;
        end
      end else begin
        if (ctl.decRemain) remain    <= remain - 1'b1;
        if (ctl.decDrain)  drainLeft <= drainLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DW    = 8,
  localparam int NW   = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxValid,
  input  logic [DW-1:0] rxData,
  output logic          rxReady,
  output logic [CW-1:0] rxCapacity,
  input  logic          addrWrEn,
  input  logic [AW-1:0] addrWrData,
  input  logic          cntWrEn,
  input  logic [CW-1:0] cntWrData,
  output logic [AW-1:0] dmaAddr,
  output logic [CW-1:0] dmaRemain,
  output logic [NW-1:0] fifoCount,
  output logic          busy,
  output logic          memValid,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  input  logic          memReady
);
  dmaCtl_t ctl;
  logic drainSel, remainZero, fifoFull, drainLast, drainNeeded;

  rxdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .cntWrEn(cntWrEn),
    .addrWrEn(addrWrEn), .memReady(memReady), .remainZero(remainZero),
    .fifoFull(fifoFull), .drainLast(drainLast), .drainNeeded(drainNeeded),
    .ctl(ctl), .busy(busy), .rxReady(rxReady), .memValid(memValid),
    .drainSel(drainSel)
  );

  rxdma_dpath #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .drainSel(drainSel),
    .rxData(rxData), .addrIn(addrWrData), .lenIn(cntWrData),
    .ptr(dmaAddr), .remain(dmaRemain), .count(fifoCount),
    .capacity(rxCapacity), .memData(memData), .remainZero(remainZero),
    .fifoFull(fifoFull), .drainLast(drainLast), .drainNeeded(drainNeeded)
  );

  assign memAddr = dmaAddr;
endmodule

// File: rtl/rxdma_engine_chk.sv
module rxdma_engine_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DW    = 8,
  localparam int NW   = $clog2(DEPTH + 1)
)(
  input logic          clk,
  input logic          rstN,
  input logic          rxReady,
  input logic          addrWrEn,
  input logic          cntWrEn,
  input logic [AW-1:0] dmaAddr,
  input logic [CW-1:0] dmaRemain,
  input logic [NW-1:0] fifoCount,
  input logic          busy,
  input logic          memValid,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memData,
  input logic          memReady
);
  // R9
  busy_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !rxReady);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !addrWrEn) |=> dmaAddr == $past(dmaAddr) + 1'b1);

  // R3
  addr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memAddr == dmaAddr);

  // R11
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memValid && !memReady && !addrWrEn) |=>
      (memValid && $stable(memData) && $stable(memAddr)));

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrWrEn |=> (dmaRemain == '0 && !busy));

  // R10
  busy_len_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cntWrEn && !addrWrEn) |=> $stable(dmaRemain));

  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == NW'(DEPTH) && dmaRemain == '0) |-> !rxReady);

  // R4
  direct_no_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRemain != '0 && !busy) |=> fifoCount <= $past(fifoCount));
endmodule

bind rxdma_engine rxdma_engine_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .rxReady(rxReady), .addrWrEn(addrWrEn),
  .cntWrEn(cntWrEn), .dmaAddr(dmaAddr), .dmaRemain(dmaRemain),
  .fifoCount(fifoCount), .busy(busy), .memValid(memValid),
  .memAddr(memAddr), .memData(memData), .memReady(memReady)
);

// File: tb/rxdma_engine_test.sv
module rxdma_engine_test;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int NW = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rstN = 0;
  logic rxValid = 0, addrWrEn = 0, cntWrEn = 0, memReady = 0;
  logic [DW-1:0] rxData = '0;
  logic [AW-1:0] addrWrData = '0;
  logic [CW-1:0] cntWrData = '0;
  logic rxReady, busy, memValid;
  logic [CW-1:0] rxCapacity, dmaRemain;
  logic [AW-1:0] dmaAddr, memAddr;
  logic [NW-1:0] fifoCount;
  logic [DW-1:0] memData;

  rxdma_engine #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DW(DW)) uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .rxCapacity(rxCapacity), .addrWrEn(addrWrEn),
    .addrWrData(addrWrData), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .dmaAddr(dmaAddr), .dmaRemain(dmaRemain), .fifoCount(fifoCount),
    .busy(busy), .memValid(memValid), .memAddr(memAddr), .memData(memData),
    .memReady(memReady)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int pRx = 50;
  int pReady = 70;

  logic [AW-1:0] mPtr = '0;
  int mRemain = 0;
  int mDrain = 0;
  logic [DW-1:0] mq[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expCap();
    if (mRemain != 0) return mRemain;
    return DEPTH - mq.size();
  endfunction

  task automatic step(input bit doCnt, input int cv, input bit doAddr, input logic [AW-1:0] av);
    bit mBusy, expReady, expValid, beat, remZero;
    string tag;
    @(negedge clk);
    rxValid    = (($urandom % 100) < pRx);
    rxData     = DW'($urandom);
    memReady   = (($urandom % 100) < pReady);
    cntWrEn    = doCnt;
    cntWrData  = CW'(cv);
    addrWrEn   = doAddr;
    addrWrData = av;
    #1;
    mBusy   = (mDrain != 0);
    remZero = (mRemain == 0);
    chk(dmaAddr == mPtr, "R8 pointer", dmaAddr, mPtr);
    chk(dmaRemain == CW'(mRemain), "R8 remaining R2", dmaRemain, mRemain);
    chk(fifoCount == NW'(mq.size()), "R5 occupancy", fifoCount, mq.size());
    chk(busy == mBusy, "R9 busy", busy, mBusy);
    chk(rxCapacity == CW'(expCap()), "R7 capacity", rxCapacity, expCap());
    expReady = !mBusy && !doCnt && (!remZero ? memReady : (mq.size() < DEPTH));
    expValid = mBusy || (!remZero && !doCnt && rxValid);
    tag = mBusy ? "R9 rxReady" : (!remZero ? "R4 rxReady" : "R5 rxReady");
    chk(rxReady == expReady, tag, rxReady, expReady);
    chk(memValid == expValid, mBusy ? "R11 memValid" : "R4 memValid", memValid, expValid);
    beat = memValid && memReady;
    if (beat) begin
      chk(memAddr == mPtr, "R3 address", memAddr, mPtr);
      if (mBusy) begin
        chk(memData == mq[0], "R3 drain order", memData, mq[0]);
        void'(mq.pop_front());
        mDrain--;
      end else begin
        chk(memData == rxData, "R4 direct data", memData, rxData);
        mRemain--;
      end
      mPtr = mPtr + 1'b1;
    end
    if (rxValid && rxReady && remZero && !mBusy) mq.push_back(rxData);
    if (doAddr) begin
      mPtr = av; mRemain = 0; mDrain = 0;
    end else if (doCnt && !mBusy) begin
      if (mq.size() < cv) begin
        mDrain = mq.size(); mRemain = cv - mq.size();
      end else begin
        mDrain = cv; mRemain = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(dmaAddr == '0, "R1 pointer", dmaAddr, 0);
    chk(dmaRemain == '0, "R1 remaining", dmaRemain, 0);
    chk(fifoCount == '0, "R1 occupancy", fifoCount, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(memValid == 1'b0, "R1 memValid", memValid, 0);
    @(negedge clk);
    rstN = 1;

    // R6 pointer load, then R5 buffer six bytes
    pRx = 0; pReady = 50;
    step(0, 0, 1, 32'h1000);
    pRx = 100;
    idle(6);
    // R2 length smaller than occupancy
    pRx = 0;
    step(1, 4, 0, '0);
    idle(12);
    // R2 length larger than occupancy, then R4 direct bytes
    step(1, 7, 0, '0);
    pRx = 60;
    idle(20);
    // R5 fill FIFO until full
    pRx = 100; pReady = 100;
    idle(24);
    // R10 length write during a slow drain
    pRx = 0; pReady = 15;
    step(1, 16, 0, '0);
    idle(3);
    step(1, 3, 0, '0);
    idle(4);
    step(1, 40, 0, '0);
    // R6 pointer write aborts the drain, same-cycle length dropped
    idle(5);
    step(1, 9, 1, 32'h2000);
    idle(4);
    pReady = 80;
    step(1, 30, 0, '0);
    idle(40);
    // R2 zero length cancels
    step(1, 0, 0, '0);
    idle(3);

    // random phase
    for (int blk = 0; blk < 12; blk++) begin
      pRx = 20 + ($urandom % 81);
      pReady = 10 + ($urandom % 91);
      for (int i = 0; i < 500; i++) begin
        bit dc, da;
        dc = (($urandom % 40) == 0);
        da = (($urandom % 150) == 0);
        step(dc, $urandom % 24, da, $urandom);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule